// File: doc/BRIEF.md
# Eight-Pin Register-Mapped GPIO with Interrupt Detection

This block is an eight-pin general-purpose I/O port behind a simple register bus with a setup phase and an access phase. Each pin can be set as an input or as an output. The block drives the output value and the output enable towards the pad ring. Data accesses use address bits as a per-pin mask. Software can therefore read or change any subset of pins in one bus access, with no read-modify-write sequence.

Inputs pass through a two-flop synchroniser. Each pin then has its own interrupt detection. A pin can be level-sensitive, with a selectable active level. It can also be edge-sensitive, on rising edges, on falling edges, or on both. Edge events are held in a raw status register until software writes one to the clear register. Level events simply follow the pin. The enabled status bits are ORed into one interrupt output.

Top module: `gpio_irq_block`

## Requirements
- R1: After reset, every register reads 0. All pins are inputs (`pin_oe` = 0), `pin_out` is 0 and `irq_out` is 0.
- R2: The direction register at offset 0x400 makes pin n an output when bit n is 1 and an input when it is 0. `pin_oe` equals this register.
- R3: A data write at an offset below 0x400 uses address bits [9:2] as a pin mask. Only masked pins take the new value from the write data.
- R4: A data write has no effect on the held output value of a pin that is an input at the time of the write. The held value still does not change when that pin later becomes an output. `pin_out` always shows the held values.
- R5: A data read returns, at each masked position, the held output value for an output pin and the synchronised input for an input pin. Every unmasked position reads 0.
- R6: When bit n of the sense register (0x404) is 0, pin n is edge-sensitive. Bit n of the event register (0x40C) then picks rising (1) or falling (0) edges. A qualifying edge sets bit n of raw status (0x414), and the bit stays set.
- R7: When bit n of the both-edges register (0x408) is 1 on an edge-sensitive pin, rising and falling edges both set raw status, whatever the event bit holds.
- R8: When sense bit n is 1, raw status bit n follows the synchronised level: high when the event bit is 1, low when it is 0. A clear write has no lasting effect while that level persists.
- R9: Writing 1 to bit n of the clear register (0x41C) clears the held edge status of pin n. Writing 0 leaves it unchanged.
- R10: Masked status (0x418) equals raw status AND the enable register (0x410). `irq_out` is 1 exactly when some masked status bit is 1.
- R11: Reads of the clear register and of unmapped offsets return 0. Writes to the raw and masked status offsets change nothing.
- R12: A change on an input pin shows in raw status within four clock cycles of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access-phase strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access phase |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Held output values |
| pin_oe | output | 8 | Output enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench writes to pins that are still inputs, then turns them into outputs. A design that let the write through would drive a stale value onto `pin_out`. It runs single-pin, multi-pin and empty address masks, both for writes and for reads. A design that ignored the mask would disturb pins it should not touch, or leak values into unmasked read bits. It drives edges of the wrong polarity and checks that no status is latched. It also checks that both-edges mode overrides the event bit. A level-sensitive pin that is still active must stay flagged after a clear, while a cleared edge pin must drop. The bench also writes 0 to the clear register, which must change nothing. Finally it writes to the read-only status offsets, which must also change nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  parameter int unsigned GPIO_PINS = 8;
  parameter int unsigned GPIO_AW   = 12;

  localparam logic [11:0] OFF_DIR   = 12'h400;
  localparam logic [11:0] OFF_SENSE = 12'h404;
  localparam logic [11:0] OFF_BOTH  = 12'h408;
  localparam logic [11:0] OFF_EVENT = 12'h40C;
  localparam logic [11:0] OFF_IE    = 12'h410;
  localparam logic [11:0] OFF_RAW   = 12'h414;
  localparam logic [11:0] OFF_MASK  = 12'h418;
  localparam logic [11:0] OFF_CLR   = 12'h41C;

  // Qualified edge trigger for one pin
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic ev, input logic both);
    if (both) return rise | fall;
    return ev ? rise : fall;
  endfunction

  // Level-mode activity for one pin given its polarity
  function automatic logic level_hit(input logic lvl, input logic ev);
    return ev ? lvl : ~lvl;
  endfunction

  // Merge new bits into old where allowed
  function automatic logic merge_bit(input logic old_v, input logic new_v,
                                     input logic allow);
    return allow ? new_v : old_v;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] ev_cfg,
  input  logic [W-1:0] both_cfg,
  output logic [W-1:0] trig
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise_w, fall_w;
    assign rise_w  = cur[i] & ~prev[i];
    assign fall_w  = ~cur[i] & prev[i];
    assign trig[i] = edge_hit(rise_w, fall_w, ev_cfg[i], both_cfg[i]);
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sense_cfg,
  input  logic [W-1:0] ev_cfg,
  input  logic [W-1:0] level_in,
  input  logic [W-1:0] trig,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] raw
);
  logic [W-1:0] held_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic set_w, clr_w;
    assign set_w = trig[i] & ~sense_cfg[i];
    assign clr_w = clr_we & clr_bits[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held_q[i] <= 1'b0;
      else if (set_w) held_q[i] <= 1'b1;   // new event wins over clear
      else if (clr_w) held_q[i] <= 1'b0;
    end

    assign raw[i] = sense_cfg[i] ? level_hit(level_in[i], ev_cfg[i]) : held_q[i];
  end
endmodule

// File: rtl/gpio_irq_block.sv
module gpio_irq_block
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = GPIO_PINS,
  parameter int unsigned AW    = GPIO_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_en,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = MASK_LO + NPINS - 1;

  logic [NPINS-1:0] dir_q, sense_q, both_q, ev_q, ie_q, dout_q;
  logic [NPINS-1:0] sync_w, prev_w, trig_w, raw_w, masked_w, pin_val_w, amask_w;
  logic             acc_w, wr_w, in_data_w, aligned_w;

  assign acc_w     = bus_sel & bus_en;
  assign wr_w      = acc_w & bus_write;
  assign aligned_w = (bus_addr[1:0] == 2'b00);
  assign in_data_w = aligned_w && (bus_addr[AW-1:MASK_HI+1] == '0);
  assign amask_w   = bus_addr[MASK_HI:MASK_LO];

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in),
    .sync_q(sync_w), .prev_q(prev_w)
  );

  gpio_event_det #(.W(NPINS)) u_det (
    .cur(sync_w), .prev(prev_w), .ev_cfg(ev_q), .both_cfg(both_q), .trig(trig_w)
  );

  gpio_irq_status #(.W(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .sense_cfg(sense_q), .ev_cfg(ev_q),
    .level_in(sync_w), .trig(trig_w),
    .clr_we(wr_w && bus_addr == AW'(OFF_CLR)), .clr_bits(bus_wdata),
    .raw(raw_w)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      ev_q    <= '0;
      ie_q    <= '0;
    end else if (wr_w) begin
      unique case (bus_addr)
        AW'(OFF_DIR):   dir_q   <= bus_wdata;
        AW'(OFF_SENSE): sense_q <= bus_wdata;
        AW'(OFF_BOTH):  both_q  <= bus_wdata;
        AW'(OFF_EVENT): ev_q    <= bus_wdata;
        AW'(OFF_IE):    ie_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  // Held output values: masked by address and by current direction
  for (genvar i = 0; i < NPINS; i++) begin : g_dout
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q[i] <= 1'b0;
      else if (wr_w && in_data_w)
        dout_q[i] <= merge_bit(dout_q[i], bus_wdata[i], amask_w[i] & dir_q[i]);
    end
    assign pin_val_w[i] = dir_q[i] ? dout_q[i] : sync_w[i];
  end

  assign masked_w = raw_w & ie_q;
  assign irq_out  = |masked_w;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (acc_w && !bus_write) begin
      if (in_data_w) bus_rdata = pin_val_w & amask_w;
      else begin
        unique case (bus_addr)
          AW'(OFF_DIR):   bus_rdata = dir_q;
          AW'(OFF_SENSE): bus_rdata = sense_q;
          AW'(OFF_BOTH):  bus_rdata = both_q;
          AW'(OFF_EVENT): bus_rdata = ev_q;
          AW'(OFF_IE):    bus_rdata = ie_q;
          AW'(OFF_RAW):   bus_rdata = raw_w;
          AW'(OFF_MASK):  bus_rdata = masked_w;
          default:        bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = GPIO_PINS,
  parameter int unsigned AW    = GPIO_AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_en,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq_out,
  input logic [NPINS-1:0] ie_q,
  input logic [NPINS-1:0] sense_q,
  input logic [NPINS-1:0] trig_w,
  input logic [NPINS-1:0] raw_w
);
  logic wr_w;
  assign wr_w = bus_sel & bus_en & bus_write;

  a_r2_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w && bus_addr == AW'(OFF_DIR)) |=> (pin_oe == $past(bus_wdata)));

  a_r4_input_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  a_r6_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_w & ~sense_q) != '0) |=> (($past(trig_w & ~sense_q) & ~sense_q & ~raw_w) == '0));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w && bus_addr == AW'(OFF_CLR)) |=>
      (($past(bus_wdata & ~trig_w) & ~sense_q & raw_w) == '0));

  a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq_out);
endmodule

bind gpio_irq_block gpio_irq_checker #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out),
  .ie_q(ie_q), .sense_q(sense_q), .trig_w(trig_w), .raw_w(raw_w)
);

// File: tb/tb_gpio_irq_block.sv
`timescale 1ns/1ps
module tb_gpio_irq_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  gpio_irq_block dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1;
    @(negedge clk); bus_sel = 0; bus_en = 0; bus_write = 0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_en = 1; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_en = 0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);   // R12: within four cycles
  endtask

  task automatic t_reset;
    rdreg(12'h400, rd); chk("R1 dir", rd, 8'h00);
    rdreg(12'h410, rd); chk("R1 enable", rd, 8'h00);
    rdreg(12'h40C, rd); chk("R1 event", rd, 8'h00);
    rdreg(12'h3FC, rd); chk("R1 data", rd, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_direction;
    wr(12'h400, 8'hF0);
    chk("R2 pin_oe", pin_oe, 8'hF0);
    rdreg(12'h400, rd); chk("R2 readback", rd, 8'hF0);
  endtask

  task automatic t_masked_write;
    wr(12'h0C0, 8'hFF);             // mask 0x30
    chk("R3 subset write", pin_out, 8'h30);
    wr(12'h3FC, 8'h0F);             // inputs 0-3 ignored, outputs 4-7 get 0
    chk("R3 full mask write", pin_out, 8'h00);
    wr(12'h3FC, 8'hA5);
    chk("R4 write to input pins ignored", pin_out, 8'hA0);
    wr(12'h000, 8'hFF);             // empty mask
    chk("R3 empty mask", pin_out, 8'hA0);
  endtask

  task automatic t_input_write;
    wr(12'h400, 8'hFF);
    chk("R4 no stale value after turning output", pin_out, 8'hA0);
    wr(12'h3FC, 8'hA5);
    chk("R4 rewrite after turning output", pin_out, 8'hA5);
  endtask

  task automatic t_read_mask;
    wr(12'h400, 8'h0F);
    set_pins(8'h96);
    rdreg(12'h3FC, rd); chk("R5 full read", rd, 8'h95);
    rdreg(12'h204, rd); chk("R5 mask 81", rd, 8'h81);
    rdreg(12'h040, rd); chk("R5 pin4 only", rd, 8'h10);
    rdreg(12'h080, rd); chk("R5 pin5 only", rd, 8'h00);
    wr(12'h400, 8'h00);
    set_pins(8'h00);
  endtask

  task automatic t_edges;
    wr(12'h41C, 8'hFF);
    rdreg(12'h414, rd); chk("R9 clear all", rd, 8'h00);
    wr(12'h40C, 8'h01);             // pin0 rising, pin1 falling
    set_pins(8'h01);
    rdreg(12'h414, rd); chk("R6 rising on pin0", rd, 8'h01);
    set_pins(8'h03);
    rdreg(12'h414, rd); chk("R6 rising ignored on falling pin1", rd, 8'h01);
    set_pins(8'h01);
    rdreg(12'h414, rd); chk("R6 falling on pin1", rd, 8'h03);
    wr(12'h41C, 8'h00);
    rdreg(12'h414, rd); chk("R9 writing 0 no effect", rd, 8'h03);
    wr(12'h41C, 8'h01);
    rdreg(12'h414, rd); chk("R9 clear pin0 only", rd, 8'h02);
    wr(12'h414, 8'hFF); wr(12'h418, 8'hFF);
    rdreg(12'h414, rd); chk("R11 status writes ignored", rd, 8'h02);
    wr(12'h41C, 8'hFF);
  endtask

  task automatic t_both;
    wr(12'h408, 8'h04);             // pin2 both edges, event bit 0
    set_pins(8'h05);
    rdreg(12'h414, rd); chk("R7 rise with both", rd, 8'h04);
    wr(12'h41C, 8'h04);
    rdreg(12'h414, rd); chk("R9 clear pin2", rd, 8'h00);
    set_pins(8'h01);
    rdreg(12'h414, rd); chk("R7 fall with both", rd, 8'h04);
    wr(12'h41C, 8'hFF);
  endtask

  task automatic t_level;
    wr(12'h404, 8'h08);
    wr(12'h40C, 8'h09);             // pin3 high level
    rdreg(12'h414, rd); chk("R8 inactive low", rd, 8'h00);
    set_pins(8'h09);
    rdreg(12'h414, rd); chk("R8 high level", rd, 8'h08);
    wr(12'h41C, 8'h08);
    rdreg(12'h414, rd); chk("R8 clear no lasting effect", rd, 8'h08);
    set_pins(8'h01);
    rdreg(12'h414, rd); chk("R8 follows level down", rd, 8'h00);
    wr(12'h40C, 8'h01);             // pin3 low level
    rdreg(12'h414, rd); chk("R8 low polarity", rd, 8'h08);
    wr(12'h404, 8'h00);
    wr(12'h41C, 8'hFF);
    rdreg(12'h414, rd); chk("R8 back to edge mode", rd, 8'h00);
  endtask

  task automatic t_irq;
    wr(12'h40C, 8'h01);
    set_pins(8'h00);
    wr(12'h41C, 8'hFF);
    set_pins(8'h01);
    rdreg(12'h414, rd); chk("R10 raw set", rd, 8'h01);
    rdreg(12'h418, rd); chk("R10 masked while disabled", rd, 8'h00);
    chk("R10 irq low while disabled", {7'b0, irq_out}, 8'h00);
    wr(12'h410, 8'h01);
    rdreg(12'h418, rd); chk("R10 masked enabled", rd, 8'h01);
    chk("R10 irq high", {7'b0, irq_out}, 8'h01);
    wr(12'h41C, 8'h01);
    chk("R10 irq drops after clear", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_unused;
    rdreg(12'h41C, rd); chk("R11 clear reads 0", rd, 8'h00);
    rdreg(12'h420, rd); chk("R11 unmapped 420", rd, 8'h00);
    rdreg(12'h7FC, rd); chk("R11 unmapped 7FC", rd, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'b0, irq_out}, 8'h00);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_masked_write();
    t_input_write();
    t_read_mask();
    t_edges();
    t_both();
    t_level();
    t_irq();
    t_unused();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule